// File: doc/BRIEF.md
# UDP Frame Receive Parser

This block sits behind a byte-wide gigabit receive interface (one byte per clock while `rx_valid` is high) and turns incoming UDP-over-IPv4 Ethernet frames into a stream of application payload bytes. It locks onto the 0x55 preamble run and the 0xD5 start byte. It then walks the 42 header bytes (Ethernet, IPv4, UDP), checks the fields that decide acceptance, and latches the sender's MAC address, IP address and port.

Payload bytes are presented one clock after they arrive, framed by first and last markers. The UDP length field, not the end of the frame, sets the payload size, so zero padding and the four trailing check bytes are never presented. Frames addressed elsewhere or of the wrong protocol are dropped silently. A frame that ends too early raises a one-clock error pulse, and a complete frame raises a one-clock done pulse. The frame check sequence itself is verified by a separate block.

Top module: `urx_frame_parser`

## Requirements
- R1: A frame starts with one or more 0x55 bytes followed by 0xD5, and the header starts on the next byte. Any other byte during the preamble, or a first byte other than 0x55, drops the frame silently: no payload, no done and no error.
- R2: The source MAC (header bytes 6..11), source IP (bytes 26..29) and source port (bytes 34..35) are taken most significant byte first and presented on `rx_src_mac`, `rx_src_ip` and `rx_src_port`. `rx_pay_len` shows the UDP length minus 8. All four stay unchanged while payload is being presented.
- R3: The destination MAC (header bytes 0..5) must equal `cfg_mac` or be all ones. Otherwise the frame is dropped silently.
- R4: The type (bytes 12..13) must be 0x0800, header byte 14 must be 0x45 (version 4, header length 5), and the protocol (byte 23) must be 0x11. Any mismatch drops the frame silently.
- R5: The destination IP (bytes 30..33) must equal `cfg_ip` and the destination port (bytes 36..37) must equal `cfg_port`. Otherwise the frame is dropped silently.
- R6: With UDP length L (bytes 38..39), exactly L-8 bytes after header byte 41 are presented in order on `pl_data`. Each byte is shown with `pl_valid` one clock after it is sampled. `pl_first` marks the first byte and `pl_last` marks byte L-8.
- R7: Bytes that follow the payload (zero padding and the 4 trailing check bytes) are never presented.
- R8: L equal to 8 gives no payload strobe and still completes. L below 8 drops the frame silently.
- R9: The UDP checksum bytes (40..41) have no effect on acceptance, whether they are zero or not.
- R10: When `rx_valid` falls after a full payload and at least 4 further bytes, `frm_done` pulses for one clock, in the clock after the first low sample.
- R11: When `rx_valid` falls during the header or the payload, or with fewer than 4 bytes after the payload, `frm_error` pulses for one clock. It never coincides with `frm_done`.
- R12: After reset, every output is zero.
- R13: A new frame that follows a single idle clock is parsed in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Frame byte present |
| rx_byte | input | 8 | Received byte |
| cfg_mac | input | 48 | Accepted destination MAC |
| cfg_ip | input | 32 | Accepted destination IP |
| cfg_port | input | 16 | Accepted destination port |
| pl_valid | output | 1 | Payload byte strobe |
| pl_data | output | 8 | Payload byte |
| pl_first | output | 1 | First payload byte of frame |
| pl_last | output | 1 | Final payload byte of frame |
| frm_done | output | 1 | Frame completed pulse |
| frm_error | output | 1 | Truncated frame pulse |
| rx_src_mac | output | 48 | Sender MAC address |
| rx_src_ip | output | 32 | Sender IP address |
| rx_src_port | output | 16 | Sender UDP port |
| rx_pay_len | output | 16 | Payload byte count of the frame |

## Verification
The end-of-frame report for one frame can fall in the same clock as the preamble of the next frame. The done pulse is still on its output while the parser samples the next 0x55. The bench provokes this by sending two frames separated by a single idle clock. It judges the result on three counts: two done pulses with no error, both payloads delivered intact and in order, and the second frame's first and last markers in the right places. Payload lengths are also swept from 0 to 24 bytes with varied preamble lengths, which moves the boundary between payload, padding and trailing bytes across every case.

// File: rtl/urx_pkg.sv
package urx_pkg;
    localparam int BYTE_W   = 8;
    localparam int MAC_W    = 48;
    localparam int IP_W     = 32;
    localparam int PORT_W   = 16;
    localparam int LEN_W    = 16;
    localparam int IDX_W    = 6;

    localparam logic [BYTE_W-1:0] PRE_BYTE  = 8'h55;
    localparam logic [BYTE_W-1:0] SFD_BYTE  = 8'hD5;
    localparam logic [15:0]       TYPE_IPV4 = 16'h0800;
    localparam logic [BYTE_W-1:0] VER_IHL   = 8'h45;
    localparam logic [BYTE_W-1:0] PROTO_UDP = 8'h11;
    localparam int UDP_HDR_BYTES = 8;
    localparam int FCS_BYTES     = 4;

    // Header byte positions counted from the byte after the start byte
    localparam int IX_DMAC_END  = 5;
    localparam int IX_SMAC_END  = 11;
    localparam int IX_TYPE_END  = 13;
    localparam int IX_VERIHL    = 14;
    localparam int IX_PROTO     = 23;
    localparam int IX_SIP_END   = 29;
    localparam int IX_DIP_END   = 33;
    localparam int IX_SPORT_END = 35;
    localparam int IX_DPORT_END = 37;
    localparam int IX_ULEN_END  = 39;
    localparam int IX_HDR_END   = 41;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_HDR, ST_PAY, ST_TAIL, ST_DROP
    } rx_state_e;

    typedef struct packed {
        logic [MAC_W-1:0]  src_mac;
        logic [IP_W-1:0]   src_ip;
        logic [PORT_W-1:0] src_port;
        logic [LEN_W-1:0]  pay_len;
    } rx_meta_t;

    function automatic logic [IDX_W-1:0] ix(input int pos);
        return IDX_W'(pos);
    endfunction
endpackage

// File: rtl/urx_hdr_check.sv
module urx_hdr_check
    import urx_pkg::*;
#(
    parameter bit ACCEPT_BCAST = 1'b1
) (
    input  logic [IDX_W-1:0] hdr_idx,
    input  logic [MAC_W-1:0] win,
    input  logic [MAC_W-1:0] cfg_mac,
    input  logic [IP_W-1:0]  cfg_ip,
    input  logic [PORT_W-1:0] cfg_port,
    output logic             reject
);
    logic mac_bcast;

    generate
        if (ACCEPT_BCAST) begin : g_bcast
            assign mac_bcast = &win;
        end else begin : g_no_bcast
            assign mac_bcast = 1'b0;
        end
    endgenerate

    always_comb begin
        reject = 1'b0;
        case (hdr_idx)
            ix(IX_DMAC_END):  reject = !(win == cfg_mac || mac_bcast);
            ix(IX_TYPE_END):  reject = win[15:0] != TYPE_IPV4;
            ix(IX_VERIHL):    reject = win[7:0] != VER_IHL;
            ix(IX_PROTO):     reject = win[7:0] != PROTO_UDP;
            ix(IX_DIP_END):   reject = win[IP_W-1:0] != cfg_ip;
            ix(IX_DPORT_END): reject = win[PORT_W-1:0] != cfg_port;
            ix(IX_ULEN_END):  reject = win[LEN_W-1:0] < LEN_W'(UDP_HDR_BYTES);
            default:          reject = 1'b0;
        endcase
    end
endmodule

// File: rtl/urx_meta_capture.sv
module urx_meta_capture
    import urx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] hdr_idx,
    input  logic [MAC_W-1:0] win,
    output rx_meta_t         meta
);
    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
        end else if (cap_en) begin
            case (hdr_idx)
                ix(IX_SMAC_END):  meta.src_mac  <= win;
                ix(IX_SIP_END):   meta.src_ip   <= win[IP_W-1:0];
                ix(IX_SPORT_END): meta.src_port <= win[PORT_W-1:0];
                ix(IX_ULEN_END):  meta.pay_len  <= win[LEN_W-1:0] - LEN_W'(UDP_HDR_BYTES);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/urx_pay_track.sv
module urx_pay_track
    import urx_pkg::*;
#(
    parameter int LW       = LEN_W,
    parameter int TAIL_MAX = FCS_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [LW-1:0] len_in,
    input  logic          pay_step,
    input  logic          tail_step,
    output logic          is_first,
    output logic          is_last,
    output logic          tail_ok
);
    localparam int TW = $clog2(TAIL_MAX + 1);

    logic [LW-1:0] cnt;
    logic [LW-1:0] len;
    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            len  <= '0;
            tcnt <= '0;
        end else if (load) begin
            cnt  <= '0;
            len  <= len_in;
            tcnt <= '0;
        end else begin
            if (pay_step)
                cnt <= cnt + LW'(1);
            if (tail_step && tcnt != TW'(TAIL_MAX))
                tcnt <= tcnt + TW'(1);
        end
    end

    assign is_first = cnt == '0;
    assign is_last  = cnt == len - LW'(1);
    assign tail_ok  = tcnt == TW'(TAIL_MAX);

    // R6: a payload byte is only taken while the count is below the length
    assert_pay_within_len_R6: assert property (@(posedge clk) disable iff (rst)
        pay_step |-> cnt < len);

    // R7: trailing-byte counter never passes its saturation point
    assert_tail_saturates_R7: assert property (@(posedge clk) disable iff (rst)
        tcnt <= TW'(TAIL_MAX));
endmodule

// File: rtl/urx_frame_parser.sv
module urx_frame_parser
    import urx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic [47:0]       cfg_mac,
    input  logic [31:0]       cfg_ip,
    input  logic [15:0]       cfg_port,
    output logic              pl_valid,
    output logic [7:0]        pl_data,
    output logic              pl_first,
    output logic              pl_last,
    output logic              frm_done,
    output logic              frm_error,
    output logic [47:0]       rx_src_mac,
    output logic [31:0]       rx_src_ip,
    output logic [15:0]       rx_src_port,
    output logic [15:0]       rx_pay_len
);
    rx_state_e        state;
    logic [IDX_W-1:0] hdr_idx;
    logic [MAC_W-BYTE_W-1:0] shreg;
    logic [MAC_W-1:0] win;
    logic             reject;
    logic             hdr_end;
    logic             trk_load, trk_first, trk_last, trk_tail_ok;
    rx_meta_t         meta;

    assign win     = {shreg, rx_byte};
    assign hdr_end = hdr_idx == ix(IX_HDR_END);
    assign trk_load = state == ST_HDR && rx_valid && hdr_end;

    urx_hdr_check u_check (
        .hdr_idx  (hdr_idx),
        .win      (win),
        .cfg_mac  (cfg_mac),
        .cfg_ip   (cfg_ip),
        .cfg_port (cfg_port),
        .reject   (reject)
    );

    urx_meta_capture u_meta (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (state == ST_HDR && rx_valid),
        .hdr_idx (hdr_idx),
        .win     (win),
        .meta    (meta)
    );

    urx_pay_track u_track (
        .clk       (clk),
        .rst       (rst),
        .load      (trk_load),
        .len_in    (meta.pay_len),
        .pay_step  (state == ST_PAY && rx_valid),
        .tail_step (state == ST_TAIL && rx_valid),
        .is_first  (trk_first),
        .is_last   (trk_last),
        .tail_ok   (trk_tail_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (rx_valid) begin
            shreg <= win[MAC_W-BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            hdr_idx   <= '0;
            pl_valid  <= 1'b0;
            pl_data   <= '0;
            pl_first  <= 1'b0;
            pl_last   <= 1'b0;
            frm_done  <= 1'b0;
            frm_error <= 1'b0;
        end else begin
            pl_valid  <= 1'b0;
            pl_first  <= 1'b0;
            pl_last   <= 1'b0;
            frm_done  <= 1'b0;
            frm_error <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (rx_valid)
                        state <= (rx_byte == PRE_BYTE) ? ST_PRE : ST_DROP;
                end
                ST_PRE: begin
                    if (!rx_valid) begin
                        state <= ST_IDLE;
                    end else if (rx_byte == SFD_BYTE) begin
                        state   <= ST_HDR;
                        hdr_idx <= '0;
                    end else if (rx_byte != PRE_BYTE) begin
                        state <= ST_DROP;
                    end
                end
                ST_HDR: begin
                    if (!rx_valid) begin
                        frm_error <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (reject) begin
                        state <= ST_DROP;
                    end else if (hdr_end) begin
                        state <= (meta.pay_len == '0) ? ST_TAIL : ST_PAY;
                    end else begin
                        hdr_idx <= hdr_idx + IDX_W'(1);
                    end
                end
                ST_PAY: begin
                    if (!rx_valid) begin
                        frm_error <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        pl_valid <= 1'b1;
                        pl_data  <= rx_byte;
                        pl_first <= trk_first;
                        pl_last  <= trk_last;
                        if (trk_last)
                            state <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (!rx_valid) begin
                        frm_done  <= trk_tail_ok;
                        frm_error <= !trk_tail_ok;
                        state     <= ST_IDLE;
                    end
                end
                default: begin
                    if (!rx_valid)
                        state <= ST_IDLE;
                end
            endcase
        end
    end

    assign rx_src_mac  = meta.src_mac;
    assign rx_src_ip   = meta.src_ip;
    assign rx_src_port = meta.src_port;
    assign rx_pay_len  = meta.pay_len;

    // R6: the first and last markers only appear on a payload strobe
    assert_marks_need_valid_R6: assert property (@(posedge clk) disable iff (rst)
        (pl_first || pl_last) |-> pl_valid);

    // R7: nothing is presented in the clock after the final payload byte
    assert_quiet_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        pl_last |=> !pl_valid);

    // R11: done and error are exclusive
    assert_done_err_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(frm_done && frm_error));

    // R11: the error report lasts one clock
    assert_err_one_clock_R11: assert property (@(posedge clk) disable iff (rst)
        frm_error |=> !frm_error);

    // R2: captured sender fields hold while later payload bytes are shown
    assert_meta_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (pl_valid && !pl_first) |-> ($stable(rx_src_mac) && $stable(rx_src_ip)
                                     && $stable(rx_src_port) && $stable(rx_pay_len)));
endmodule

// File: tb/urx_frame_parser_tb.sv
module urx_frame_parser_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [47:0] CFG_MAC  = 48'h02_1A_2B_3C_4D_5E;
    localparam logic [31:0] CFG_IP   = 32'hC0A8_0164;
    localparam logic [15:0] CFG_PORT = 16'd4660;
    localparam logic [47:0] SRC_MAC  = 48'h06_11_22_33_44_55;
    localparam logic [31:0] SRC_IP   = 32'h0A00_0007;
    localparam logic [15:0] SRC_PORT = 16'd777;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic pl_valid, pl_first, pl_last, frm_done, frm_error;
    logic [7:0] pl_data;
    logic [47:0] rx_src_mac;
    logic [31:0] rx_src_ip;
    logic [15:0] rx_src_port, rx_pay_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    urx_frame_parser u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cfg_mac(CFG_MAC), .cfg_ip(CFG_IP), .cfg_port(CFG_PORT),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_first(pl_first), .pl_last(pl_last),
        .frm_done(frm_done), .frm_error(frm_error),
        .rx_src_mac(rx_src_mac), .rx_src_ip(rx_src_ip),
        .rx_src_port(rx_src_port), .rx_pay_len(rx_pay_len)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // frame knobs
    int          k_pre, k_pay, k_fcs, k_ulen, k_seed;
    bit          k_bad_pre;
    logic [47:0] k_dmac;
    logic [15:0] k_type, k_dport, k_csum;
    logic [7:0]  k_verihl, k_proto;
    logic [31:0] k_dip;

    logic [7:0] fb [0:255];
    int flen, pay_start;
    int end_cyc, pay_cyc;

    // monitor state
    logic [7:0] got [0:255];
    int n_got, first_pos, last_pos, n_done, n_err, done_cyc, first_cyc;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run did not end", 0, 1);
        finish_run();
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (pl_valid) begin
                if (pl_first) begin
                    if (first_pos < 0) first_cyc = cyc;
                    first_pos = n_got;
                end
                if (pl_last) last_pos = n_got;
                if (n_got < 256) got[n_got] = pl_data;
                n_got++;
            end
            if (frm_done) begin n_done++; done_cyc = cyc; end
            if (frm_error) n_err++;
        end
    end

    function automatic logic [7:0] pay_byte(input int k, input int seed);
        return 8'((k * 7 + seed * 13 + 1) & 8'hFF);
    endfunction

    task automatic defaults();
        k_pre = 7; k_pay = 10; k_fcs = 4; k_ulen = -1; k_seed = 1; k_bad_pre = 0;
        k_dmac = CFG_MAC; k_type = 16'h0800; k_verihl = 8'h45; k_proto = 8'h11;
        k_dip = CFG_IP; k_dport = CFG_PORT; k_csum = 16'h0000;
    endtask

    task automatic put(input logic [7:0] b);
        fb[flen] = b;
        flen++;
    endtask

    task automatic build();
        int ulen;
        ulen = (k_ulen < 0) ? k_pay + 8 : k_ulen;
        flen = 0;
        for (int i = 0; i < k_pre; i++) put((k_bad_pre && i == 2) ? 8'h12 : 8'h55);
        put(8'hD5);
        for (int i = 5; i >= 0; i--) put(k_dmac[i*8 +: 8]);
        for (int i = 5; i >= 0; i--) put(SRC_MAC[i*8 +: 8]);
        put(k_type[15:8]); put(k_type[7:0]);
        put(k_verihl); put(8'h00);
        put(8'((28 + k_pay) >> 8)); put(8'(28 + k_pay));
        put(8'h00); put(8'h00); put(8'h00); put(8'h00);
        put(8'h40); put(k_proto); put(8'h5A); put(8'h3C);
        for (int i = 3; i >= 0; i--) put(SRC_IP[i*8 +: 8]);
        for (int i = 3; i >= 0; i--) put(k_dip[i*8 +: 8]);
        put(SRC_PORT[15:8]); put(SRC_PORT[7:0]);
        put(k_dport[15:8]); put(k_dport[7:0]);
        put(8'(ulen >> 8)); put(8'(ulen));
        put(k_csum[15:8]); put(k_csum[7:0]);
        pay_start = flen;
        for (int i = 0; i < k_pay; i++) put(pay_byte(i, k_seed));
        for (int i = k_pay; i < 18; i++) put(8'h00);
        for (int i = 0; i < k_fcs; i++) put(8'hC3 + 8'(i));
    endtask

    task automatic clear_mon();
        n_got = 0; first_pos = -1; last_pos = -1; n_done = 0; n_err = 0;
        done_cyc = -1; first_cyc = -1;
    endtask

    task automatic drive(input int gap);
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = fb[i];
            if (i == pay_start) pay_cyc = cyc;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h00;
        end_cyc  = cyc;
        repeat (gap) @(negedge clk);
    endtask

    task automatic expect_good(input int np, input string tag);
        int bad;
        bad = 0;
        chk(n_got == np, "R6", {tag, " payload count"}, n_got, np);
        for (int i = 0; i < np && i < 256; i++)
            if (got[i] != pay_byte(i, k_seed)) bad++;
        chk(bad == 0, "R6", {tag, " payload bytes wrong"}, bad, 0);
        chk(n_got <= np, "R7", {tag, " padding/check bytes leaked"}, n_got, np);
        if (np > 0) begin
            chk(first_pos == 0, "R6", {tag, " first marker position"}, first_pos, 0);
            chk(last_pos == np - 1, "R6", {tag, " last marker position"}, last_pos, np - 1);
            chk(first_cyc == pay_cyc + 1, "R6", {tag, " first byte latency"}, first_cyc, pay_cyc + 1);
        end else begin
            chk(first_pos == -1 && last_pos == -1, "R8", {tag, " markers on empty payload"},
                first_pos, -1);
        end
        chk(n_done == 1, "R10", {tag, " done count"}, n_done, 1);
        chk(done_cyc == end_cyc + 1, "R10", {tag, " done timing"}, done_cyc, end_cyc + 1);
        chk(n_err == 0, "R11", {tag, " error count"}, n_err, 0);
        chk(rx_src_mac == SRC_MAC, "R2", {tag, " source MAC"}, longint'(rx_src_mac), longint'(SRC_MAC));
        chk(rx_src_ip == SRC_IP, "R2", {tag, " source IP"}, rx_src_ip, SRC_IP);
        chk(rx_src_port == SRC_PORT, "R2", {tag, " source port"}, rx_src_port, SRC_PORT);
        chk(rx_pay_len == 16'(np), "R2", {tag, " payload length"}, rx_pay_len, np);
    endtask

    task automatic expect_silent(input string req, input string tag);
        chk(n_got == 0, req, {tag, " payload strobes on dropped frame"}, n_got, 0);
        chk(n_done == 0 && n_err == 0, req, {tag, " status on dropped frame"}, n_done + n_err, 0);
    endtask

    task automatic run_drop(input string req, input string tag);
        build(); clear_mon(); drive(4); expect_silent(req, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!pl_valid && !pl_first && !pl_last && !frm_done && !frm_error, "R12",
            "control outputs in reset", 1, 0);
        chk(rx_src_mac == 0 && rx_src_ip == 0 && rx_src_port == 0 && rx_pay_len == 0 && pl_data == 0,
            "R12", "field outputs in reset", 1, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        clear_mon();

        // sweep payload length, preamble length, address kind and checksum (R1 R3 R6 R7 R8 R9)
        for (int n = 0; n <= 24; n++) begin
            defaults();
            k_pay  = n;
            k_pre  = 1 + (n % 7);
            k_seed = n + 3;
            k_dmac = (n % 2 == 1) ? 48'hFFFF_FFFF_FFFF : CFG_MAC;
            k_csum = (n % 3 == 0) ? 16'hBEEF : 16'h0000;
            build(); clear_mon(); drive(3);
            expect_good(n, $sformatf("sweep len %0d R1 R3 R9", n));
        end

        // R1: stray byte in preamble
        defaults(); k_bad_pre = 1; run_drop("R1", "bad preamble");
        // R1: frame beginning without 0x55
        defaults(); k_pre = 0; run_drop("R1", "no preamble");
        // R3: foreign destination MAC
        defaults(); k_dmac = 48'h02_1A_2B_3C_4D_5F; run_drop("R3", "other MAC");
        // R4
        defaults(); k_type = 16'h0806; run_drop("R4", "wrong type");
        defaults(); k_verihl = 8'h46; run_drop("R4", "header length 6");
        defaults(); k_verihl = 8'h65; run_drop("R4", "version 6");
        defaults(); k_proto = 8'h06; run_drop("R4", "wrong protocol");
        // R5
        defaults(); k_dip = CFG_IP ^ 32'h1; run_drop("R5", "other IP");
        defaults(); k_dport = CFG_PORT + 16'd1; run_drop("R5", "other port");
        // R8: UDP length below 8
        defaults(); k_ulen = 4; run_drop("R8", "short UDP length");

        // R11: cut inside header
        defaults(); build(); flen = k_pre + 1 + 20; clear_mon(); drive(4);
        chk(n_err == 1 && n_done == 0, "R11", "header cut error count", n_err, 1);
        chk(n_got == 0, "R11", "header cut payload", n_got, 0);

        // R11: cut inside payload
        defaults(); k_pay = 30; k_seed = 9; build(); flen = pay_start + 10; clear_mon(); drive(4);
        chk(n_err == 1 && n_done == 0, "R11", "payload cut error count", n_err, 1);
        chk(n_got == 10, "R11", "payload cut bytes shown", n_got, 10);
        chk(last_pos == -1, "R11", "payload cut last marker", last_pos, -1);

        // R11: only two trailing bytes after a full payload
        defaults(); k_pay = 30; k_fcs = 2; build(); clear_mon(); drive(4);
        chk(n_err == 1 && n_done == 0, "R11", "short trailer error count", n_err, 1);
        chk(n_got == 30 && last_pos == 29, "R11", "short trailer payload", n_got, 30);

        // R13: one idle clock between frames; done of frame A overlaps preamble of frame B
        defaults(); k_pay = 5; k_seed = 1; build(); clear_mon(); drive(0);
        defaults(); k_pay = 12; k_seed = 2; build(); drive(4);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 5; i++) if (got[i] != pay_byte(i, 1)) bad++;
            for (int i = 0; i < 12; i++) if (got[5 + i] != pay_byte(i, 2)) bad++;
            chk(n_got == 17, "R13", "back-to-back byte count", n_got, 17);
            chk(bad == 0, "R13", "back-to-back bytes wrong", bad, 0);
            chk(n_done == 2 && n_err == 0, "R13", "back-to-back done count", n_done, 2);
            chk(first_pos == 5 && last_pos == 16, "R13", "second frame markers", last_pos, 16);
        end

        // recovery after drops: a normal frame is still accepted (R1)
        defaults(); k_pay = 40; k_seed = 5; build(); clear_mon(); drive(3);
        expect_good(40, "long frame R1");

        finish_run();
    end
endmodule